// File: doc/BRIEF.md
# PWM Fault Shutdown Guard

This block sits between a PWM generator and the output pins. It watches three hardware fault sources: two active-low external trip pins and one active-high over-current comparator input. It also watches a software force-off bit. When any enabled source is active, every guarded PWM output is driven to a programmed off-level. That path is combinational from the pins, so it does not wait for a clock edge. The generator upstream gets no feedback from this block, so its counter keeps running while the outputs are held off.

Each hardware source also passes through a two-flop synchronizer. The synchronized value sets a sticky status bit, and any set status bit raises the interrupt line. Software reads the status to find the cause and clears it by writing 1. A small state machine keeps the outputs held until the cause has gone and software has cleared the status.

The state machine has three states:
- RUN: outputs pass through.
- TRIP: an enabled synchronized source or the software bit is active.
- CLEARWAIT: the sources are gone but status is still set.

It has five transitions:
- RUN→TRIP on any active cause.
- TRIP→RUN when the cause drops and status is already zero.
- TRIP→CLEARWAIT when the cause drops and status is non-zero.
- CLEARWAIT→TRIP when a cause returns.
- CLEARWAIT→RUN when status reads zero.

Top module: `pwm_trip_guard`

## Requirements
- R1: After reset, status reads 0, irq is 0, the source-enable register reads 7, the off-level register reads 0, the guard mask has all bits set, and pwm_out equals pwm_in. Register addresses are: 0 control (bit 0 = software force-off), 1 source enable, 2 status, 3 off-level, 4 guard mask.
- R2: In the same cycle, with no clock edge needed, trip pin A or trip pin B at logic 0 with its enable bit set drives every guarded output to its off-level bit.
- R3: The comparator input at logic 1 with its enable bit set forces the guarded outputs in the same way, also without a clock edge.
- R4: Control bit 0 at 1 forces the guarded outputs to the off-level with no status bit set. One clock edge after the bit is written back to 0, the outputs pass through again.
- R5: A source whose enable bit is 0 neither forces the outputs nor sets its status bit.
- R6: Status bit 0 is pin A, bit 1 is pin B and bit 2 is the comparator. A bit sets on the third rising edge after its enabled source becomes active. irq is 1 whenever any status bit is 1. Several bits can be set at once.
- R7: Writing 1 to a status bit clears it. A clear has no effect while the synchronized source is still active, because setting wins.
- R8: After a hardware trip, the outputs stay forced until the source is inactive and its status has been cleared. They are released one rising edge after status reads zero.
- R9: An output whose guard-mask bit is 0 follows pwm_in at all times, including during a trip.
- R10: The state machine follows RUN, TRIP and CLEARWAIT with the five transitions listed above. The outputs are held in every state except RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trip_a_n | input | 1 | External trip pin A, active low |
| trip_b_n | input | 1 | External trip pin B, active low |
| ocp_in | input | 1 | Over-current comparator output, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DW | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | DW | Register read data, combinational |
| pwm_in | input | N_OUT | PWM levels from the generator |
| pwm_out | output | N_OUT | Guarded PWM levels to the pins |
| irq | output | 1 | Fault interrupt |

## Verification
The forced output level is due within the same cycle as the pin change, so the bench checks it 1 ns after driving the pin, with no edge in between. Status and irq are due on the third rising edge after the source becomes active: two synchronizer flops plus the status register. The bench therefore waits exactly three edges before it compares them. Release of the outputs is due one edge after status goes to zero, and the bench samples once before that edge, expecting the outputs still held, and once after it, expecting them released. Every expected item is computed from the register values the bench itself wrote, pushed to a queue, and compared by the monitor 1 ns after an edge.

// File: rtl/pwm_trip_pkg.sv
package pwm_trip_pkg;

    localparam int NSRC      = 3;
    localparam int REG_AW    = 3;
    localparam int SRC_PIN_A = 0;
    localparam int SRC_PIN_B = 1;
    localparam int SRC_CMP   = 2;

    typedef enum logic [1:0] {
        GS_RUN       = 2'd0,
        GS_TRIP      = 2'd1,
        GS_CLEARWAIT = 2'd2
    } guard_state_t;

    typedef enum logic [REG_AW-1:0] {
        RA_CTRL    = 3'd0,
        RA_SRC_EN  = 3'd1,
        RA_STATUS  = 3'd2,
        RA_OFF_LVL = 3'd3,
        RA_GUARD   = 3'd4
    } reg_addr_t;

endpackage

// File: rtl/trip_sync.sv
module trip_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);

    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            stage_q[0] <= d_in;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign d_out = stage_q[STAGES-1];

endmodule

// File: rtl/trip_regs.sv
module trip_regs
    import pwm_trip_pkg::*;
#(
    parameter int N_OUT = 6,
    parameter int DW    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    input  logic [NSRC-1:0]   fault_sync,
    output logic [DW-1:0]     rd_data,
    output logic              sw_off,
    output logic [NSRC-1:0]   src_en,
    output logic [NSRC-1:0]   status,
    output logic [N_OUT-1:0]  off_lvl,
    output logic [N_OUT-1:0]  guard_mask
);

    localparam logic [DW-1:0] EN_RESET = DW'({NSRC{1'b1}});

    logic [DW-1:0]   ctrl_q;
    logic [DW-1:0]   en_q;
    logic [DW-1:0]   off_q;
    logic [DW-1:0]   guard_q;
    logic [NSRC-1:0] stat_q;
    logic [NSRC-1:0] clr_vec;
    logic [NSRC-1:0] set_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            en_q    <= EN_RESET;
            off_q   <= '0;
            guard_q <= '1;
        end else if (wr_en) begin
            unique case (wr_addr)
                RA_CTRL:    ctrl_q  <= wr_data;
                RA_SRC_EN:  en_q    <= wr_data;
                RA_OFF_LVL: off_q   <= wr_data;
                RA_GUARD:   guard_q <= wr_data;
                default:    ;
            endcase
        end
    end

    always_comb begin
        clr_vec = '0;
        if (wr_en && (wr_addr == RA_STATUS)) begin
            clr_vec = wr_data[NSRC-1:0];
        end
        set_vec = fault_sync & en_q[NSRC-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_vec) | set_vec;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            RA_CTRL:    rd_data = ctrl_q;
            RA_SRC_EN:  rd_data = en_q;
            RA_STATUS:  rd_data[NSRC-1:0] = stat_q;
            RA_OFF_LVL: rd_data = off_q;
            RA_GUARD:   rd_data = guard_q;
            default:    rd_data = '0;
        endcase
    end

    assign sw_off     = ctrl_q[0];
    assign src_en     = en_q[NSRC-1:0];
    assign status     = stat_q;
    assign off_lvl    = off_q[N_OUT-1:0];
    assign guard_mask = guard_q[N_OUT-1:0];

endmodule

// File: rtl/trip_fsm.sv
module trip_fsm
    import pwm_trip_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fault_now,
    input  logic         status_any,
    output guard_state_t state,
    output logic         hold_active
);

    guard_state_t state_q;
    guard_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GS_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_RUN: begin
                if (fault_now) state_d = GS_TRIP;
            end
            GS_TRIP: begin
                if (!fault_now) state_d = status_any ? GS_CLEARWAIT : GS_RUN;
            end
            GS_CLEARWAIT: begin
                if (fault_now)        state_d = GS_TRIP;
                else if (!status_any) state_d = GS_RUN;
            end
            default: state_d = GS_RUN;
        endcase
    end

    always_comb begin
        state       = state_q;
        hold_active = (state_q != GS_RUN);
    end

endmodule

// File: rtl/trip_gate.sv
module trip_gate #(
    parameter int N_OUT = 6
) (
    input  logic [N_OUT-1:0] pwm_in,
    input  logic [N_OUT-1:0] off_lvl,
    input  logic [N_OUT-1:0] guard_mask,
    input  logic             hold_active,
    input  logic             async_trip,
    output logic [N_OUT-1:0] pwm_out
);

    logic force_all;
    assign force_all = hold_active | async_trip;

    for (genvar g = 0; g < N_OUT; g++) begin : g_lane
        assign pwm_out[g] = (guard_mask[g] && force_all) ? off_lvl[g] : pwm_in[g];
    end

endmodule

// File: rtl/pwm_trip_guard.sv
module pwm_trip_guard
    import pwm_trip_pkg::*;
#(
    parameter int N_OUT       = 6,
    parameter int DW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trip_a_n,
    input  logic              trip_b_n,
    input  logic              ocp_in,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [DW-1:0]     rd_data,
    input  logic [N_OUT-1:0]  pwm_in,
    output logic [N_OUT-1:0]  pwm_out,
    output logic              irq
);

    logic [NSRC-1:0]  raw_fault;
    logic [NSRC-1:0]  fault_sync;
    logic [NSRC-1:0]  src_en;
    logic [NSRC-1:0]  status;
    logic [N_OUT-1:0] off_lvl;
    logic [N_OUT-1:0] guard_mask;
    logic             sw_off;
    logic             async_trip;
    logic             fault_now;
    logic             hold_active;
    guard_state_t     state;

    always_comb begin
        raw_fault            = '0;
        raw_fault[SRC_PIN_A] = ~trip_a_n;
        raw_fault[SRC_PIN_B] = ~trip_b_n;
        raw_fault[SRC_CMP]   = ocp_in;
    end

    trip_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (raw_fault),
        .d_out (fault_sync)
    );

    trip_regs #(.N_OUT(N_OUT), .DW(DW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .fault_sync (fault_sync),
        .rd_data    (rd_data),
        .sw_off     (sw_off),
        .src_en     (src_en),
        .status     (status),
        .off_lvl    (off_lvl),
        .guard_mask (guard_mask)
    );

    assign async_trip = (|(raw_fault & src_en)) | sw_off;
    assign fault_now  = (|(fault_sync & src_en)) | sw_off;

    trip_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .fault_now   (fault_now),
        .status_any  (|status),
        .state       (state),
        .hold_active (hold_active)
    );

    trip_gate #(.N_OUT(N_OUT)) u_gate (
        .pwm_in      (pwm_in),
        .off_lvl     (off_lvl),
        .guard_mask  (guard_mask),
        .hold_active (hold_active),
        .async_trip  (async_trip),
        .pwm_out     (pwm_out)
    );

    assign irq = |status;

endmodule

// File: rtl/pwm_trip_guard_chk.sv
module pwm_trip_guard_chk
    import pwm_trip_pkg::*;
#(
    parameter int N_OUT = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trip_a_n,
    input logic [NSRC-1:0]   src_en,
    input logic [NSRC-1:0]   status,
    input logic [NSRC-1:0]   fault_sync,
    input logic              sw_off,
    input logic [N_OUT-1:0]  pwm_in,
    input logic [N_OUT-1:0]  pwm_out,
    input logic [N_OUT-1:0]  off_lvl,
    input logic [N_OUT-1:0]  guard_mask,
    input logic              irq,
    input logic              hold_active,
    input logic              wr_en,
    input logic [REG_AW-1:0] wr_addr,
    input logic [NSRC-1:0]   wr_lo
);

    logic [NSRC-1:0] clr_req;
    assign clr_req = (wr_en && wr_addr == RA_STATUS) ? wr_lo : '0;

    // R2
    pin_a_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_en[SRC_PIN_A] && !trip_a_n) |-> ((pwm_out & guard_mask) == (off_lvl & guard_mask)));

    // R4
    sw_off_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_off |-> ((pwm_out & guard_mask) == (off_lvl & guard_mask)));

    // R5
    disabled_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[SRC_PIN_B]) |-> $past(src_en[SRC_PIN_B]));

    // R6
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(fault_sync & src_en) != '0));

    // R7
    sticky_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(status) & ~$past(clr_req)) & ~status) == '0));

    // R8
    hold_while_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status != '0) |-> hold_active);

    // R9
    unguarded_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~guard_mask & (pwm_out ^ pwm_in)) == '0));

endmodule

bind pwm_trip_guard pwm_trip_guard_chk #(.N_OUT(N_OUT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .trip_a_n    (trip_a_n),
    .src_en      (src_en),
    .status      (status),
    .fault_sync  (fault_sync),
    .sw_off      (sw_off),
    .pwm_in      (pwm_in),
    .pwm_out     (pwm_out),
    .off_lvl     (off_lvl),
    .guard_mask  (guard_mask),
    .irq         (irq),
    .hold_active (hold_active),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_lo       (wr_data[NSRC-1:0])
);

// File: tb/sim_pwm_trip_guard.sv
`timescale 1ns/1ps
module sim_pwm_trip_guard;

    localparam int N  = 6;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          trip_a_n = 1'b1;
    logic          trip_b_n = 1'b1;
    logic          ocp_in = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [2:0]    rd_addr = 3'd2;
    logic [DW-1:0] rd_data;
    logic [N-1:0]  pwm_in = 6'b101101;
    logic [N-1:0]  pwm_out;
    logic          irq;

    always #4 clk = ~clk;

    pwm_trip_guard #(.N_OUT(N), .DW(DW), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .trip_a_n(trip_a_n), .trip_b_n(trip_b_n),
        .ocp_in(ocp_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pwm_in(pwm_in),
        .pwm_out(pwm_out), .irq(irq)
    );

    typedef struct packed {
        logic [N-1:0] out;
        logic [2:0]   st;
        logic         irq;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    pushed = 0;
    int    popped = 0;
    int    total  = 0;
    int    fails  = 0;
    bit    done   = 0;
    event  push_ev;

    logic [N-1:0] off_v   = '0;
    logic [N-1:0] guard_v = '1;

    function automatic logic [N-1:0] forced(input logic [N-1:0] p);
        return (p & ~guard_v) | (off_v & guard_v);
    endfunction

    // monitor: pops expected items and compares them with the ports
    initial begin
        forever begin
            @(push_ev);
            while (exp_q.size() > 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                total++;
                if (pwm_out !== e.out || rd_data[2:0] !== e.st || irq !== e.irq) begin
                    fails++;
                    $display("FAIL %s: out=%b st=%b irq=%b expected out=%b st=%b irq=%b",
                             t, pwm_out, rd_data[2:0], irq, e.out, e.st, e.irq);
                end
                popped++;
            end
        end
    end

    // driver side: push an expected item and wait until it is compared
    task automatic expect_now(input logic [N-1:0] o, input logic [2:0] s,
                              input logic i, input string t);
        exp_t e;
        e.out = o; e.st = s; e.irq = i;
        exp_q.push_back(e);
        tag_q.push_back(t);
        pushed++;
        -> push_ev;
        wait (popped == pushed);
    endtask

    task automatic check_val(input logic [DW-1:0] act, input logic [DW-1:0] exp_v,
                             input string t);
        total++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s: got %h expected %h", t, act, exp_v);
        end
    endtask

    task automatic write_reg(input logic [2:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: run did not complete");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        edges(1);
        // R1 reset state
        expect_now(pwm_in, 3'b000, 1'b0, "R1 reset outputs/status");
        rd_addr = 3'd1; #1;
        check_val(rd_data, 16'h0007, "R1 enable reset");
        rd_addr = 3'd3; #1;
        check_val(rd_data, 16'h0000, "R1 off-level reset");
        rd_addr = 3'd4; #1;
        check_val(rd_data, 16'hFFFF, "R1 guard reset");
        rd_addr = 3'd2;

        off_v = 6'b000011;
        write_reg(3'd3, 16'(off_v));

        // R2 pin A: forced with no edge
        @(negedge clk);
        trip_a_n = 1'b0; #1;
        expect_now(forced(pwm_in), 3'b000, 1'b0, "R2 pin A immediate force");
        edges(3);
        expect_now(forced(pwm_in), 3'b001, 1'b1, "R6 pin A status on third edge");
        // R7 clear while still active has no effect
        write_reg(3'd2, 16'h0001);
        expect_now(forced(pwm_in), 3'b001, 1'b1, "R7 clear ignored while active");
        @(negedge clk);
        trip_a_n = 1'b1;
        edges(4);
        expect_now(forced(pwm_in), 3'b001, 1'b1, "R8 hold in CLEARWAIT (R10)");
        write_reg(3'd2, 16'h0001);
        expect_now(forced(pwm_in), 3'b000, 1'b0, "R7 cleared, R8 still held one edge");
        edges(1);
        expect_now(pwm_in, 3'b000, 1'b0, "R8 released CLEARWAIT->RUN (R10)");

        // R3 comparator
        @(negedge clk);
        ocp_in = 1'b1; #1;
        expect_now(forced(pwm_in), 3'b000, 1'b0, "R3 comparator immediate force");
        edges(3);
        expect_now(forced(pwm_in), 3'b100, 1'b1, "R6 comparator status bit 2");
        @(negedge clk);
        ocp_in = 1'b0;
        edges(4);
        write_reg(3'd2, 16'h0004);
        edges(1);
        expect_now(pwm_in, 3'b000, 1'b0, "R8 released after comparator clear");

        // R5 disabled pin B
        write_reg(3'd1, 16'h0005);
        @(negedge clk);
        trip_b_n = 1'b0; #1;
        expect_now(pwm_in, 3'b000, 1'b0, "R5 disabled pin B no force");
        edges(4);
        expect_now(pwm_in, 3'b000, 1'b0, "R5 disabled pin B no status");
        @(negedge clk);
        trip_b_n = 1'b1;
        edges(4);
        write_reg(3'd1, 16'h0007);

        // R4 software force-off
        write_reg(3'd0, 16'h0001);
        expect_now(forced(pwm_in), 3'b000, 1'b0, "R4 software force, no status");
        write_reg(3'd0, 16'h0000);
        expect_now(forced(pwm_in), 3'b000, 1'b0, "R4 held until next edge (R10 TRIP)");
        edges(1);
        expect_now(pwm_in, 3'b000, 1'b0, "R4 released TRIP->RUN (R10)");

        // R9 guard mask with pin B
        guard_v = 6'b001111;
        write_reg(3'd4, 16'(guard_v));
        @(negedge clk);
        trip_b_n = 1'b0; #1;
        expect_now(forced(pwm_in), 3'b000, 1'b0, "R9 partial guard force");
        pwm_in = 6'b011010; #1;
        expect_now(forced(pwm_in), 3'b000, 1'b0, "R9 unguarded lanes follow input");
        edges(3);
        expect_now(forced(pwm_in), 3'b010, 1'b1, "R6 pin B status bit 1");
        @(negedge clk);
        trip_b_n = 1'b1;
        edges(4);
        write_reg(3'd2, 16'h0002);
        edges(1);
        expect_now(pwm_in, 3'b000, 1'b0, "R8 released after pin B clear");

        // R6 two sources together
        guard_v = '1;
        write_reg(3'd4, 16'hFFFF);
        @(negedge clk);
        trip_a_n = 1'b0; ocp_in = 1'b1;
        edges(3);
        expect_now(forced(pwm_in), 3'b101, 1'b1, "R6 two sources latched");
        @(negedge clk);
        trip_a_n = 1'b1; ocp_in = 1'b0;
        edges(4);
        write_reg(3'd2, 16'h0001);
        expect_now(forced(pwm_in), 3'b100, 1'b1, "R7 partial clear keeps bit 2");
        write_reg(3'd2, 16'h0004);
        edges(1);
        expect_now(pwm_in, 3'b000, 1'b0, "R8 released after full clear");

        finish_run();
    end

endmodule